// File: doc/BRIEF.md
# Write-Once Word Store Controller

This block emulates a one-time-programmable storage array. The array holds 64 words. Each word has 22 bits: a 16-bit data field and a 6-bit SECDED check field. After power-up every bit is clear. A bit can be set by programming, and once set it can never be cleared.

Callers issue commands over a valid/ready handshake. Each command carries:
- an operation,
- a base address,
- a length code, which is the number of words minus one, with at most four words,
- the write data, packed as one 16-bit lane per word.

The controller runs through the words one at a time and returns one response pulse. The response carries an error code and the read words.

There are two kinds of access:
- **Protected reads and writes** use the SECDED code. A protected write refuses to program a word if doing so would require clearing an already-set bit. A protected read corrects single-bit faults and stops at the first word it cannot correct.
- **Raw reads and writes** bypass the code. They see, or OR into, the stored bits directly.

Top module: `otp_word_ctrl`

## Requirements
- R1: After reset, `reqReady`=1, `rspValid`=0, `fatalAlert`=0 and `rspErr`=0. Until an accepted command with code 0 (start-up) arrives, every other command is accepted and ignored. The start-up command yields exactly one response with `rspErr`=0.
- R2: Command code 1 is a protected read. Word i of the command is returned in `rspData[i*22 +: 22]` as the corrected 16-bit data, with bits [21:16] of that word forced to zero. Slots past the last word read are zero.
- R3: Command code 2 is a protected write. It programs the word {overall parity, c[4:0], d[15:0]}, where:
  - bits [15:0] hold the data;
  - data bit i belongs to codeword position p_i, the i-th integer counting upward from 3 that is not a power of two;
  - check bit k, stored at bit 16+k, is the XOR of the data bits whose p_i has bit k set;
  - bit 21 is the XOR of the other 21 bits.
- R4: Programming only sets bits. The stored result is the old word ORed with the new pattern. A protected write whose pattern includes every bit already stored succeeds with `rspErr`=0.
- R5: A protected write is refused for a word when (old word AND new pattern) differs from the old word. That word is left unchanged and `rspErr`=3. The other words of the same command are still programmed.
- R6: A protected read of a word with one flipped bit returns the corrected data and reports `rspErr`=1. The read continues with the remaining words.
- R7: A protected read that meets a word it cannot correct returns that word's raw data bits in its slot and reports `rspErr`=2. It reads no further words, so later slots stay zero.
- R8: Command code 3 is a raw read. It returns all 22 stored bits of each word and always reports `rspErr`=0.
- R9: Command code 4 is a raw write. It ORs {6'b0, data} into each word without any check. Word i of any command uses address (base + i) mod 64, for length code + 1 words.
- R10: In the idle state, command codes 0, 5, 6 and 7 are accepted and ignored. They produce no response and leave the handshake ready.
- R11: `reqReady` is low while a command runs. Each command produces exactly one single-cycle `rspValid` pulse, after which `reqReady` returns high.
- R12: `fatalAlert` stays low during legal operation. An illegal state encoding sends the controller to a terminal error state, which it never leaves and which raises `fatalAlert`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Command valid |
| reqReady | output | 1 | Command accepted when high together with valid |
| reqCmd | input | 3 | Operation code |
| reqAddr | input | 6 | Base word address |
| reqSize | input | 2 | Number of words minus one |
| reqWdata | input | 64 | Write data, 16 bits per word lane |
| rspValid | output | 1 | One-cycle completion pulse |
| rspErr | output | 2 | 0 none, 1 corrected, 2 uncorrectable, 3 write refused |
| rspData | output | 88 | Read words, 22 bits per lane |
| fatalAlert | output | 1 | Controller in terminal error state |

## Verification
The assertions assume that reset is applied before any command is issued. They also assume that request fields are judged only in the cycle where valid and ready are both high, and that state corruption arises only from faults, never from stimulus. The bench issues one command at a time and waits for the response pulse before issuing the next, so no request is ever presented while the controller is busy. Random commands work inside a narrow address window. This makes the array fill up, which exercises refused writes and corrected and uncorrectable reads. Directed cases add address wrap, an early stop on a read, and ignored codes.

// File: rtl/otp_word_pkg.sv
package otp_word_pkg;
  parameter int DataW = 16;
  parameter int ChkW  = 6;
  parameter int WordW = DataW + ChkW;
  parameter int SynW  = ChkW - 1;

  typedef enum logic [2:0] {
    CmdInit     = 3'd0,
    CmdRead     = 3'd1,
    CmdWrite    = 3'd2,
    CmdReadRaw  = 3'd3,
    CmdWriteRaw = 3'd4
  } otpCmd_e;

  typedef enum logic [3:0] {
    StReset, StInit, StIdle, StRead, StReadWait,
    StWrCheck, StWrWait, StWrite, StError
  } otpState_e;

  parameter logic [1:0] ErrNone   = 2'd0;
  parameter logic [1:0] ErrFixed  = 2'd1;
  parameter logic [1:0] ErrUncorr = 2'd2;
  parameter logic [1:0] ErrBlank  = 2'd3;

  typedef struct packed {
    logic cmdLatch;
    logic cntClr;
    logic cntInc;
    logic arrRead;
    logic capRead;
    logic capOld;
    logic progWord;
    logic rspFire;
  } otpStrobe_t;

  typedef struct packed {
    logic [1:0]       status;
    logic [DataW-1:0] data;
  } eccRes_t;

  // Codeword slot of data bit idx: idx-th non-power-of-two from 3 upward.
  function automatic logic [SynW-1:0] slotOf(int idx);
    int n = 0;
    logic [SynW-1:0] r = '0;
    for (int q = 3; q < (1 << SynW); q++) begin
      if ((q & (q - 1)) != 0) begin
        if (n == idx) r = SynW'(q);
        n++;
      end
    end
    return r;
  endfunction

  function automatic logic [SynW-1:0] synOf(logic [DataW-1:0] d);
    logic [SynW-1:0] s = '0;
    for (int i = 0; i < DataW; i++) begin
      if (d[i]) s = s ^ slotOf(i);
    end
    return s;
  endfunction

  function automatic logic [WordW-1:0] eccEncode(logic [DataW-1:0] d);
    logic [SynW-1:0] c;
    c = synOf(d);
    return {(^d) ^ (^c), c, d};
  endfunction

  function automatic eccRes_t eccDecode(logic [WordW-1:0] w);
    eccRes_t         r;
    logic [SynW-1:0] syn;
    logic            hit;
    syn      = synOf(w[DataW-1:0]) ^ w[WordW-2:DataW];
    r.data   = w[DataW-1:0];
    r.status = ErrNone;
    hit      = 1'b0;
    if (^w) begin
      for (int i = 0; i < DataW; i++) begin
        if (syn == slotOf(i)) begin
          r.data[i] = ~w[i];
          hit       = 1'b1;
        end
      end
      // overall-bit or check-bit fault still leaves data intact
      if (hit || ((syn & (syn - 1'b1)) == '0)) r.status = ErrFixed;
      else r.status = ErrUncorr;
    end else if (syn != '0) begin
      r.status = ErrUncorr;
    end
    return r;
  endfunction
endpackage

// File: rtl/otp_word_ctrl_fsm.sv
module otp_word_ctrl_fsm
  import otp_word_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqCmd,
  input  logic       cntLast,
  input  logic       rdUncorr,
  output logic       reqReady,
  output otpStrobe_t strobe,
  output logic       fatalAlert
);
  otpState_e state, nxt;

  always_comb begin
    nxt    = state;
    strobe = '0;
    case (state)
      StReset: if (reqValid && reqCmd == CmdInit) nxt = StInit;
      StInit: begin
        strobe.rspFire = 1'b1;
        nxt            = StIdle;
      end
      StIdle: if (reqValid) begin
        case (reqCmd)
          CmdRead, CmdReadRaw: begin
            strobe.cmdLatch = 1'b1;
            strobe.cntClr   = 1'b1;
            nxt             = StRead;
          end
          CmdWrite, CmdWriteRaw: begin
            strobe.cmdLatch = 1'b1;
            strobe.cntClr   = 1'b1;
            nxt             = StWrCheck;
          end
          default: nxt = StIdle;
        endcase
      end
      StRead: begin
        strobe.arrRead = 1'b1;
        nxt            = StReadWait;
      end
      StReadWait: begin
        strobe.capRead = 1'b1;
        if (rdUncorr || cntLast) begin
          strobe.rspFire = 1'b1;
          nxt            = StIdle;
        end else begin
          strobe.cntInc = 1'b1;
          nxt           = StRead;
        end
      end
      StWrCheck: begin
        strobe.arrRead = 1'b1;
        nxt            = StWrWait;
      end
      StWrWait: begin
        strobe.capOld = 1'b1;
        if (cntLast) begin
          strobe.cntClr = 1'b1;
          nxt           = StWrite;
        end else begin
          strobe.cntInc = 1'b1;
          nxt           = StWrCheck;
        end
      end
      StWrite: begin
        strobe.progWord = 1'b1;
        if (cntLast) begin
          strobe.rspFire = 1'b1;
          nxt            = StIdle;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      StError: nxt = StError;
      default: nxt = StError;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= StReset;
    else       state <= nxt;
  end

  assign reqReady   = (state == StReset) || (state == StIdle);
  assign fatalAlert = (state == StError);

  assert_reset_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == StReset && !(reqValid && reqCmd == CmdInit)) |=> state == StReset);
  assert_read_stops_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == StReadWait && rdUncorr) |=> state == StIdle);
  assert_error_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    (state == StError) |=> (state == StError && fatalAlert));
endmodule

// File: rtl/otp_word_ctrl_dp.sv
module otp_word_ctrl_dp
  import otp_word_pkg::*;
#(
  parameter int AddrW = 6,
  parameter int SizeW = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  otpStrobe_t               strobe,
  input  logic [2:0]               reqCmd,
  input  logic [AddrW-1:0]         reqAddr,
  input  logic [SizeW-1:0]         reqSize,
  input  logic [(1<<SizeW)*DataW-1:0] reqWdata,
  output logic                     cntLast,
  output logic                     rdUncorr,
  output logic                     rspValid,
  output logic [1:0]               rspErr,
  output logic [(1<<SizeW)*WordW-1:0] rspData
);
  localparam int Depth = 1 << AddrW;
  localparam int Burst = 1 << SizeW;

  logic [WordW-1:0] mem [Depth];
  logic [WordW-1:0] arrQ;
  logic [WordW-1:0] rdBuf [Burst];
  logic [WordW-1:0] oldBuf [Burst];
  logic [DataW-1:0] wrBuf [Burst];
  logic [AddrW-1:0] baseQ;
  logic [SizeW-1:0] sizeQ, cnt;
  logic             eccQ;
  logic [1:0]       errQ;
  logic             rspValidQ;

  logic [AddrW-1:0] curAddr;
  logic [WordW-1:0] oldWord, newWord;
  logic             blocked;
  eccRes_t          dec;

  function automatic logic [1:0] worst(logic [1:0] a, logic [1:0] b);
    return (a > b) ? a : b;
  endfunction

  always_comb begin
    curAddr  = baseQ + AddrW'(cnt);
    oldWord  = oldBuf[cnt];
    newWord  = eccQ ? eccEncode(wrBuf[cnt]) : {{ChkW{1'b0}}, wrBuf[cnt]};
    blocked  = eccQ && ((oldWord & newWord) != oldWord);
    dec      = eccDecode(arrQ);
    rdUncorr = eccQ && (dec.status == ErrUncorr);
    cntLast  = (cnt == sizeQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < Depth; i++) mem[i] <= '0;
      for (int i = 0; i < Burst; i++) begin
        rdBuf[i]  <= '0;
        oldBuf[i] <= '0;
        wrBuf[i]  <= '0;
      end
      arrQ      <= '0;
      baseQ     <= '0;
      sizeQ     <= '0;
      cnt       <= '0;
      eccQ      <= 1'b0;
      errQ      <= ErrNone;
      rspValidQ <= 1'b0;
    end else begin
      rspValidQ <= strobe.rspFire;
      if (strobe.cntClr)      cnt <= '0;
      else if (strobe.cntInc) cnt <= cnt + 1'b1;
      if (strobe.arrRead) arrQ <= mem[curAddr];
      if (strobe.capOld)  oldBuf[cnt] <= arrQ;
      if (strobe.cmdLatch) begin
        baseQ <= reqAddr;
        sizeQ <= reqSize;
        eccQ  <= (reqCmd == CmdRead) || (reqCmd == CmdWrite);
        errQ  <= ErrNone;
        for (int i = 0; i < Burst; i++) begin
          rdBuf[i] <= '0;
          wrBuf[i] <= reqWdata[i*DataW +: DataW];
        end
      end else if (strobe.capRead) begin
        rdBuf[cnt] <= eccQ ? {{ChkW{1'b0}}, dec.data} : arrQ;
        if (eccQ) errQ <= worst(errQ, dec.status);
      end else if (strobe.progWord) begin
        if (blocked) errQ <= worst(errQ, ErrBlank);
        else         mem[curAddr] <= oldWord | newWord;
      end
    end
  end

  for (genvar g = 0; g < Burst; g++) begin : g_pack
    assign rspData[g*WordW +: WordW] = rdBuf[g];
  end
  assign rspValid = rspValidQ;
  assign rspErr   = errQ;

  assert_cnt_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClr |=> cnt == '0);
  assert_raw_no_status_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capRead && !eccQ) |=> $stable(errQ));
  assert_keeps_bits_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.progWord |=> ((mem[$past(curAddr)] & $past(oldWord)) == $past(oldWord)));
  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspValidQ |=> !rspValidQ);
endmodule

// File: rtl/otp_word_ctrl.sv
module otp_word_ctrl
  import otp_word_pkg::*;
#(
  parameter int AddrW = 6,
  parameter int SizeW = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  output logic                        reqReady,
  input  logic [2:0]                  reqCmd,
  input  logic [AddrW-1:0]            reqAddr,
  input  logic [SizeW-1:0]            reqSize,
  input  logic [(1<<SizeW)*DataW-1:0] reqWdata,
  output logic                        rspValid,
  output logic [1:0]                  rspErr,
  output logic [(1<<SizeW)*WordW-1:0] rspData,
  output logic                        fatalAlert
);
  otpStrobe_t strobe;
  logic       cntLast, rdUncorr;

  otp_word_ctrl_fsm u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCmd(reqCmd),
    .cntLast(cntLast), .rdUncorr(rdUncorr), .reqReady(reqReady),
    .strobe(strobe), .fatalAlert(fatalAlert)
  );

  otp_word_ctrl_dp #(.AddrW(AddrW), .SizeW(SizeW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqCmd(reqCmd),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .cntLast(cntLast), .rdUncorr(rdUncorr), .rspValid(rspValid),
    .rspErr(rspErr), .rspData(rspData)
  );
endmodule

// File: tb/otp_word_ctrl_bench.sv
module otp_word_ctrl_bench;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [2:0]  reqCmd = '0;
  logic [5:0]  reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic [63:0] reqWdata = '0;
  logic        rspValid;
  logic [1:0]  rspErr;
  logic [87:0] rspData;
  logic        fatalAlert;

  int checks = 0;
  int errs   = 0;
  logic [21:0] model [64];

  always #(ClkPeriod/2) clk = ~clk;

  otp_word_ctrl u_otp_word_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCmd(reqCmd), .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspErr(rspErr), .rspData(rspData), .fatalAlert(fatalAlert)
  );

  task automatic chk(input bit ok, input string tag, input logic [87:0] act, input logic [87:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Codeword built by positions 1..21; powers of two carry the check bits.
  function automatic logic [21:0] refEnc(logic [15:0] d);
    logic [21:1] cw;
    logic [4:0]  c;
    logic        x;
    int          k;
    cw = '0; c = '0; k = 0;
    for (int p = 1; p <= 21; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[k];
        k++;
      end
    end
    for (int b = 0; b < 5; b++) begin
      x = 1'b0;
      for (int p = 1; p <= 21; p++)
        if (((p >> b) & 1) != 0 && (p & (p - 1)) != 0) x = x ^ cw[p];
      c[b] = x;
    end
    return {(^d) ^ (^c), c, d};
  endfunction

  // Brute-force decode: nearest codeword within distance one.
  task automatic refDec(input logic [21:0] w, output logic [1:0] st, output logic [15:0] d);
    logic [21:0] cand;
    st = 2'd2; d = w[15:0];
    if (refEnc(w[15:0]) == w) begin
      st = 2'd0;
    end else begin
      for (int j = 0; j < 22; j++) begin
        cand = w ^ (22'd1 << j);
        if (refEnc(cand[15:0]) == cand) begin
          st = 2'd1; d = cand[15:0];
        end
      end
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  endtask

  task automatic sendIgnored(input logic [2:0] cmd, input string tag);
    bit ok = 1'b1;
    @(negedge clk);
    reqValid = 1'b1; reqCmd = cmd; reqAddr = 6'd0; reqSize = 2'd0;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (int n = 0; n < 8; n++) begin
      if (rspValid || !reqReady) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, tag, {87'd0, rspValid}, 88'd0);
  endtask

  task automatic runCmd(input logic [2:0] cmd, input logic [5:0] addr, input logic [1:0] size,
                        input logic [63:0] wd, input string tag);
    logic [87:0] expData = '0;
    logic [1:0]  expErr = 2'd0;
    logic [1:0]  st;
    logic [15:0] dd;
    logic [5:0]  a;
    logic [21:0] nw;
    bit          ecc = (cmd == 3'd1) || (cmd == 3'd2);
    bit          stop = 1'b0;
    for (int i = 0; i <= int'(size); i++) begin
      a = addr + 6'(i);
      if (cmd == 3'd1 || cmd == 3'd3) begin
        if (!stop) begin
          if (ecc) begin
            refDec(model[a], st, dd);
            expData[i*22 +: 22] = {6'd0, dd};
            if (st > expErr) expErr = st;
            if (st == 2'd2) stop = 1'b1;
          end else begin
            expData[i*22 +: 22] = model[a];
          end
        end
      end else begin
        nw = ecc ? refEnc(wd[i*16 +: 16]) : {6'd0, wd[i*16 +: 16]};
        if (ecc && ((model[a] & nw) != model[a])) expErr = 2'd3;
        else model[a] = model[a] | nw;
      end
    end
    @(negedge clk);
    reqValid = 1'b1; reqCmd = cmd; reqAddr = addr; reqSize = size; reqWdata = wd;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(!reqReady, "R11 busy", {87'd0, reqReady}, 88'd0);
    for (int n = 0; n < 100 && !rspValid; n++) @(negedge clk);
    chk(rspValid, "R11 response", {87'd0, rspValid}, 88'd1);
    chk(rspErr == expErr, {tag, " err"}, {86'd0, rspErr}, {86'd0, expErr});
    chk(rspData == expData, {tag, " data"}, rspData, expData);
    chk(!fatalAlert, "R12 alert", {87'd0, fatalAlert}, 88'd0);
    @(negedge clk);
    chk(!rspValid && reqReady, "R11 pulse", {86'd0, rspValid, reqReady}, 88'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !rspValid && !fatalAlert && rspErr == 2'd0, "R1 reset",
        {84'd0, reqReady, rspValid, fatalAlert, |rspErr}, {84'd0, 4'b1000});
    // R1: reads before start-up are swallowed
    sendIgnored(3'd1, "R1 pre-init");
    @(negedge clk);
    reqValid = 1'b1; reqCmd = 3'd0;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (int n = 0; n < 10 && !rspValid; n++) @(negedge clk);
    chk(rspValid && rspErr == 2'd0, "R1 init", {86'd0, rspValid, |rspErr}, {86'd0, 2'b10});
    @(negedge clk);

    runCmd(3'd2, 6'd5, 2'd1, {32'd0, 16'h00F0, 16'h1234}, "R3 write");
    runCmd(3'd1, 6'd5, 2'd1, '0, "R2 read");
    runCmd(3'd3, 6'd5, 2'd1, '0, "R3 raw view");
    runCmd(3'd4, 6'd5, 2'd0, {48'd0, 16'h0001}, "R4 raw or");
    runCmd(3'd1, 6'd5, 2'd1, '0, "R6 corrected");
    runCmd(3'd3, 6'd5, 2'd0, '0, "R8 raw read");
    runCmd(3'd2, 6'd11, 2'd0, {48'd0, 16'h0F0F}, "R3 write");
    runCmd(3'd2, 6'd11, 2'd0, {48'd0, 16'h0F0F}, "R4 same data");
    runCmd(3'd4, 6'd10, 2'd0, {48'd0, 16'h0003}, "R9 raw write");
    runCmd(3'd1, 6'd9, 2'd3, '0, "R7 early stop");
    runCmd(3'd3, 6'd9, 2'd3, '0, "R8 raw no status");
    runCmd(3'd2, 6'd20, 2'd0, {48'd0, 16'h00FF}, "R3 write");
    runCmd(3'd2, 6'd20, 2'd1, {32'd0, 16'h0A0A, 16'h0F00}, "R5 refused");
    runCmd(3'd3, 6'd20, 2'd1, '0, "R5 unchanged");
    runCmd(3'd2, 6'd63, 2'd1, {32'd0, 16'hBEEF, 16'h0C0C}, "R9 wrap write");
    runCmd(3'd1, 6'd62, 2'd3, '0, "R9 wrap read");
    sendIgnored(3'd5, "R10 code5");
    sendIgnored(3'd6, "R10 code6");
    sendIgnored(3'd7, "R10 code7");
    sendIgnored(3'd0, "R10 code0");
    runCmd(3'd1, 6'd5, 2'd1, '0, "R10 state kept");

    for (int k = 0; k < 250; k++) begin
      logic [2:0]  c;
      logic [63:0] d;
      c = 3'(1 + ($urandom % 4));
      d = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
      runCmd(c, 6'(32 + ($urandom % 8)), 2'($urandom % 4), d, "R2 random");
    end
    finishRun();
  end
endmodule